// File: doc/BRIEF.md
# Host Command Decoder and Step Sequencer

This block sits between a host-to-card command FIFO and the processing engines of a spiking-network accelerator. It reads 512-bit command words and decodes an 8-bit opcode held in the top byte. Memory and neuron access requests go out, repacked, to two downstream command FIFOs. A parameter command updates a set of network configuration registers. Two execute commands start a run of simulation time steps.

A run is sequenced as follows. In continuous mode each step first asks a separate axon unpacker to load its input events, using a start/done handshake. The step then fires a one-cycle run pulse to the engines and waits for their phase-2 completion flag. After that flag it also waits for a fixed stretch of consecutive quiet cycles, during which the spike FIFO must stay empty, so that late spikes can drain. A step counter, a step limit, a 64-bit cycle timer and running/done flags record the progress of the run. The sequencer state is exported for debug.

Top module: `host_cmd_sequencer`

## Requirements
- R1: While rst_n is low (asynchronous, active-low) dbg_state is 0 and run_active, run_finished, step_count, step_limit, run_cycles and every cfg_* output are zero, even when reset arrives in the middle of a run; one clock after release dbg_state is 1.
- R2: dbg_state encodes the sequencer as 0 reset, 1 idle, 2 axon-load start, 3 axon-load wait, 4 step issue, 5 quiet wait, 6 run finish; host_pop is only ever high in state 1.
- R3: Opcode 2 (bits [511:504]) forwards word bits [279:0] unchanged on syn_cmd with one syn_push, where bit 279 is the write flag (1 = write), [278:256] the row address and [255:0] the data; the word is popped in the same cycle.
- R4: Opcode 3 forwards word bits [53:0] on nrn_cmd with one nrn_push, where bit 53 is the write flag, [52:36] the neuron address and [35:0] the neuron data; the word is popped in the same cycle.
- R5: While the target FIFO of opcode 2 or 3 reports full, the word is neither popped nor pushed; once full drops, exactly one push and one pop follow and the sequencer stays idle.
- R6: Opcode 4 loads cfg_inputs from [16:0], cfg_outputs from [33:17], the signed cfg_threshold from [69:34] and cfg_model from [71:70].
- R7: Any opcode other than 1, 2, 3, 4, 6 and 7 is popped and dropped: no push, no parameter, counter or flag change, and the sequencer stays idle.
- R8: On an execute command, one clock after the pop run_active is 1 and run_finished, step_count and run_cycles are 0; opcode 6 sets step_limit to 0 and ignores the payload, opcode 7 loads step_limit from word bits [31:0].
- R9: Opcode 1 raises axon_start for one cycle and returns to idle after axon_done; in an opcode-7 run every step is preceded by one axon_start/axon_done exchange, and every step issues step_run for exactly one cycle.
- R10: A step leaves the quiet-wait state only after 31 consecutive cycles in it with phase2_done high and spike_empty high, plus the cycle in which the full count is seen (32 quiet cycles in state 5 when quiet persists); any non-quiet cycle restarts the count.
- R11: A run performs step_limit + 1 steps and ends with step_count equal to step_limit, run_active 0 and run_finished 1; a limit of 0 gives one step and no increment.
- R12: run_cycles ends a run equal to the number of clock cycles during which run_active was high.
- R13: No command word is popped while a run or axon load is in progress; a word waiting in the FIFO is taken only after the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_empty | input | 1 | Host command FIFO empty |
| host_word | input | 512 | Head word of the host command FIFO (first-word fall-through) |
| host_pop | output | 1 | Pop the head word |
| syn_full | input | 1 | Synapse-memory command FIFO full |
| syn_cmd | output | 280 | Synapse-memory command |
| syn_push | output | 1 | Push syn_cmd |
| nrn_full | input | 1 | Neuron-state command FIFO full |
| nrn_cmd | output | 54 | Neuron-state command |
| nrn_push | output | 1 | Push nrn_cmd |
| axon_start | output | 1 | One-cycle request to the axon unpacker |
| axon_done | input | 1 | Axon unpacker finished |
| phase2_done | input | 1 | Downstream step completion flag |
| spike_empty | input | 1 | Spike FIFO empty |
| step_run | output | 1 | One-cycle step start pulse |
| run_active | output | 1 | Run in progress |
| run_finished | output | 1 | Run completed |
| step_limit | output | 32 | Last step index of the run |
| step_count | output | 32 | Current step index |
| run_cycles | output | 64 | Clock cycles spent with run_active high |
| cfg_inputs | output | 17 | Number of input axons |
| cfg_outputs | output | 17 | Number of monitored outputs |
| cfg_threshold | output | 36 | Signed firing threshold |
| cfg_model | output | 2 | Neuron model select |
| dbg_state | output | 3 | Sequencer state code |

## Verification
The bench builds the block with its default parameters. The 5-bit quiet counter therefore gives the real 31-cycle window, and the full 512-bit field offsets are used, so the terminal-count boundary and each packing position are exercised as they will be in use. Runs with limits 0 to 4 reach both the zero-limit single step and the multi-step increment path. Spike-FIFO glitches placed part-way through a wait show that the quiet count restarts. A sweep over all 250 undefined opcodes, and a reset that arrives mid-run, cover the remaining decode and recovery corners.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OP_AXON  = 8'd1;
  localparam logic [OPC_W-1:0] OP_SYN   = 8'd2;
  localparam logic [OPC_W-1:0] OP_NRN   = 8'd3;
  localparam logic [OPC_W-1:0] OP_PARAM = 8'd4;
  localparam logic [OPC_W-1:0] OP_STEP  = 8'd6;
  localparam logic [OPC_W-1:0] OP_CONT  = 8'd7;

  typedef enum logic [2:0] {
    ST_RESET     = 3'd0,
    ST_IDLE      = 3'd1,
    ST_AXON_GO   = 3'd2,
    ST_AXON_WAIT = 3'd3,
    ST_STEP      = 3'd4,
    ST_QUIET     = 3'd5,
    ST_FINISH    = 3'd6
  } seq_state_e;
endpackage

// File: rtl/hcs_quiet_timer.sv
module hcs_quiet_timer #(
  parameter int WAIT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_wait,
  input  logic              phase2_done,
  input  logic              spike_empty,
  output logic              quiet_full
);
  localparam logic [WAIT_W-1:0] FULL = '1;

  logic [WAIT_W-1:0] quiet_cnt;

  // next value of the quiet counter: advance on a quiet cycle, restart otherwise
  function automatic logic [WAIT_W-1:0] next_quiet(input logic [WAIT_W-1:0] c, input logic q);
    if (q) return c + 1'b1;
    return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet_cnt <= '0;
    else        quiet_cnt <= next_quiet(quiet_cnt, in_wait & phase2_done & spike_empty);
  end

  assign quiet_full = (quiet_cnt == FULL);
endmodule

// File: rtl/hcs_run_regs.sv
module hcs_run_regs #(
  parameter int CNT_W = 32,
  parameter int TMR_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_clear,
  input  logic             limit_take,
  input  logic [CNT_W-1:0] limit_word,
  input  logic             step_adv,
  input  logic             run_end,
  output logic [CNT_W-1:0] step_limit,
  output logic [CNT_W-1:0] step_count,
  output logic [TMR_W-1:0] run_cycles,
  output logic             run_active,
  output logic             run_finished,
  output logic             last_step
);
  // the step now ending is the last one when the index has reached the limit
  function automatic logic is_last(input logic [CNT_W-1:0] idx, input logic [CNT_W-1:0] lim);
    return idx == lim;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_limit   <= '0;
      step_count   <= '0;
      run_cycles   <= '0;
      run_active   <= 1'b0;
      run_finished <= 1'b0;
    end else if (exec_clear) begin
      step_limit   <= limit_take ? limit_word : '0;
      step_count   <= '0;
      run_cycles   <= '0;
      run_active   <= 1'b1;
      run_finished <= 1'b0;
    end else begin
      if (step_adv)   step_count <= step_count + 1'b1;
      if (run_active) run_cycles <= run_cycles + 1'b1;
      if (run_end) begin
        run_active   <= 1'b0;
        run_finished <= 1'b1;
      end
    end
  end

  assign last_step = is_last(step_count, step_limit);
endmodule

// File: rtl/hcs_ctrl_fsm.sv
module hcs_ctrl_fsm
  import hcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_empty,
  input  logic [OPC_W-1:0] opcode,
  input  logic             syn_full,
  input  logic             nrn_full,
  input  logic             axon_done,
  input  logic             quiet_full,
  input  logic             last_step,
  input  logic             run_active,
  output logic             host_pop,
  output logic             syn_push,
  output logic             nrn_push,
  output logic             param_load,
  output logic             exec_clear,
  output logic             limit_take,
  output logic             axon_start,
  output logic             step_run,
  output logic             step_adv,
  output logic             run_end,
  output seq_state_e       state
);
  seq_state_e nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= nxt;
  end

  always_comb begin
    nxt        = state;
    host_pop   = 1'b0;
    syn_push   = 1'b0;
    nrn_push   = 1'b0;
    param_load = 1'b0;
    exec_clear = 1'b0;
    limit_take = 1'b0;
    axon_start = 1'b0;
    step_run   = 1'b0;
    step_adv   = 1'b0;
    run_end    = 1'b0;
    case (state)
      ST_RESET: nxt = ST_IDLE;
      ST_IDLE: begin
        if (!host_empty) begin
          case (opcode)
            OP_AXON: begin
              host_pop = 1'b1;
              nxt      = ST_AXON_GO;
            end
            OP_SYN: begin
              if (!syn_full) begin
                host_pop = 1'b1;
                syn_push = 1'b1;
              end
            end
            OP_NRN: begin
              if (!nrn_full) begin
                host_pop = 1'b1;
                nrn_push = 1'b1;
              end
            end
            OP_PARAM: begin
              host_pop   = 1'b1;
              param_load = 1'b1;
            end
            OP_STEP: begin
              host_pop   = 1'b1;
              exec_clear = 1'b1;
              nxt        = ST_STEP;
            end
            OP_CONT: begin
              host_pop   = 1'b1;
              exec_clear = 1'b1;
              limit_take = 1'b1;
              nxt        = ST_AXON_GO;
            end
            default: host_pop = 1'b1;
          endcase
        end
      end
      ST_AXON_GO: begin
        axon_start = 1'b1;
        nxt        = ST_AXON_WAIT;
      end
      ST_AXON_WAIT: begin
        if (axon_done) nxt = run_active ? ST_STEP : ST_IDLE;
      end
      ST_STEP: begin
        step_run = 1'b1;
        nxt      = ST_QUIET;
      end
      ST_QUIET: begin
        if (quiet_full) begin
          if (last_step) begin
            nxt = ST_FINISH;
          end else begin
            step_adv = 1'b1;
            nxt      = ST_AXON_GO;
          end
        end
      end
      ST_FINISH: begin
        run_end = 1'b1;
        nxt     = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/host_cmd_sequencer.sv
module host_cmd_sequencer
  import hcs_pkg::*;
#(
  parameter int WORD_W     = 512,
  parameter int SYN_ADDR_W = 23,
  parameter int SYN_DATA_W = 256,
  parameter int NRN_ADDR_W = 17,
  parameter int NRN_DATA_W = 36,
  parameter int NIN_W      = 17,
  parameter int NOUT_W     = 17,
  parameter int THR_W      = 36,
  parameter int MODEL_W    = 2,
  parameter int CNT_W      = 32,
  parameter int TMR_W      = 64,
  parameter int WAIT_W     = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 host_empty,
  input  logic [WORD_W-1:0]                    host_word,
  output logic                                 host_pop,
  input  logic                                 syn_full,
  output logic [SYN_ADDR_W+SYN_DATA_W:0]       syn_cmd,
  output logic                                 syn_push,
  input  logic                                 nrn_full,
  output logic [NRN_ADDR_W+NRN_DATA_W:0]       nrn_cmd,
  output logic                                 nrn_push,
  output logic                                 axon_start,
  input  logic                                 axon_done,
  input  logic                                 phase2_done,
  input  logic                                 spike_empty,
  output logic                                 step_run,
  output logic                                 run_active,
  output logic                                 run_finished,
  output logic [CNT_W-1:0]                     step_limit,
  output logic [CNT_W-1:0]                     step_count,
  output logic [TMR_W-1:0]                     run_cycles,
  output logic [NIN_W-1:0]                     cfg_inputs,
  output logic [NOUT_W-1:0]                    cfg_outputs,
  output logic signed [THR_W-1:0]              cfg_threshold,
  output logic [MODEL_W-1:0]                   cfg_model,
  output logic [2:0]                           dbg_state
);
  localparam int SYN_W     = 1 + SYN_ADDR_W + SYN_DATA_W;
  localparam int NRN_W     = 1 + NRN_ADDR_W + NRN_DATA_W;
  localparam int OFS_OUT   = NIN_W;
  localparam int OFS_THR   = NIN_W + NOUT_W;
  localparam int OFS_MODEL = OFS_THR + THR_W;

  // named internal events
  logic             param_load;
  logic             exec_clear;
  logic             limit_take;
  logic             step_adv;
  logic             run_end;
  logic             last_step;
  logic             quiet_full;
  logic [OPC_W-1:0] opcode;
  seq_state_e       state;

  assign opcode  = host_word[WORD_W-1 -: OPC_W];
  assign syn_cmd = host_word[SYN_W-1:0];
  assign nrn_cmd = host_word[NRN_W-1:0];

  hcs_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_empty (host_empty),
    .opcode     (opcode),
    .syn_full   (syn_full),
    .nrn_full   (nrn_full),
    .axon_done  (axon_done),
    .quiet_full (quiet_full),
    .last_step  (last_step),
    .run_active (run_active),
    .host_pop   (host_pop),
    .syn_push   (syn_push),
    .nrn_push   (nrn_push),
    .param_load (param_load),
    .exec_clear (exec_clear),
    .limit_take (limit_take),
    .axon_start (axon_start),
    .step_run   (step_run),
    .step_adv   (step_adv),
    .run_end    (run_end),
    .state      (state)
  );

  hcs_quiet_timer #(.WAIT_W(WAIT_W)) u_quiet (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_wait     (state == ST_QUIET),
    .phase2_done (phase2_done),
    .spike_empty (spike_empty),
    .quiet_full  (quiet_full)
  );

  hcs_run_regs #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_run (
    .clk          (clk),
    .rst_n        (rst_n),
    .exec_clear   (exec_clear),
    .limit_take   (limit_take),
    .limit_word   (host_word[CNT_W-1:0]),
    .step_adv     (step_adv),
    .run_end      (run_end),
    .step_limit   (step_limit),
    .step_count   (step_count),
    .run_cycles   (run_cycles),
    .run_active   (run_active),
    .run_finished (run_finished),
    .last_step    (last_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_inputs    <= '0;
      cfg_outputs   <= '0;
      cfg_threshold <= '0;
      cfg_model     <= '0;
    end else if (param_load) begin
      cfg_inputs    <= host_word[NIN_W-1:0];
      cfg_outputs   <= host_word[OFS_THR-1:OFS_OUT];
      cfg_threshold <= signed'(host_word[OFS_MODEL-1:OFS_THR]);
      cfg_model     <= host_word[OFS_MODEL+MODEL_W-1:OFS_MODEL];
    end
  end

  assign dbg_state = state;
endmodule

// File: rtl/hcs_checker.sv
module hcs_checker #(
  parameter int CNT_W = 32,
  parameter int TMR_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       dbg_state,
  input logic             host_pop,
  input logic             syn_push,
  input logic             syn_full,
  input logic             nrn_push,
  input logic             nrn_full,
  input logic             step_run,
  input logic             run_active,
  input logic             run_finished,
  input logic [CNT_W-1:0] step_count,
  input logic [TMR_W-1:0] run_cycles,
  input logic             exec_clear,
  input logic             quiet_full
);
  a_r2_pop_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    host_pop |-> dbg_state == 3'd1);

  a_r5_syn_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    syn_push |-> !syn_full);

  a_r5_nrn_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    nrn_push |-> !nrn_full);

  a_r9_run_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    step_run |=> !step_run);

  a_r10_leave_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dbg_state) == 3'd5 && dbg_state != 3'd5) |-> $past(quiet_full));

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    run_finished |-> !run_active);

  a_r12_timer_advances: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_active) && !$past(exec_clear)) |-> run_cycles == $past(run_cycles) + 1'b1);

  a_r8_start_state: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exec_clear) |-> (run_active && !run_finished && step_count == '0));

  a_r13_no_pop_running: assert property (@(posedge clk) disable iff (!rst_n)
    run_active |-> !host_pop);
endmodule

bind host_cmd_sequencer hcs_checker #(.CNT_W(CNT_W), .TMR_W(TMR_W)) i_hcs_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .dbg_state    (dbg_state),
  .host_pop     (host_pop),
  .syn_push     (syn_push),
  .syn_full     (syn_full),
  .nrn_push     (nrn_push),
  .nrn_full     (nrn_full),
  .step_run     (step_run),
  .run_active   (run_active),
  .run_finished (run_finished),
  .step_count   (step_count),
  .run_cycles   (run_cycles),
  .exec_clear   (exec_clear),
  .quiet_full   (quiet_full)
);

// File: tb/test_host_cmd_sequencer.sv
module test_host_cmd_sequencer;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_empty;
  logic [511:0]  host_word;
  logic          host_pop;
  logic          syn_full = 1'b0;
  logic [279:0]  syn_cmd;
  logic          syn_push;
  logic          nrn_full = 1'b0;
  logic [53:0]   nrn_cmd;
  logic          nrn_push;
  logic          axon_start;
  logic          axon_done = 1'b0;
  logic          phase2_done = 1'b0;
  logic          spike_empty = 1'b1;
  logic          step_run;
  logic          run_active;
  logic          run_finished;
  logic [31:0]   step_limit;
  logic [31:0]   step_count;
  logic [63:0]   run_cycles;
  logic [16:0]   cfg_inputs;
  logic [16:0]   cfg_outputs;
  logic signed [35:0] cfg_threshold;
  logic [1:0]    cfg_model;
  logic [2:0]    dbg_state;

  always #4 clk = ~clk;

  host_cmd_sequencer i_host_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .host_empty(host_empty), .host_word(host_word),
    .host_pop(host_pop), .syn_full(syn_full), .syn_cmd(syn_cmd), .syn_push(syn_push),
    .nrn_full(nrn_full), .nrn_cmd(nrn_cmd), .nrn_push(nrn_push),
    .axon_start(axon_start), .axon_done(axon_done), .phase2_done(phase2_done),
    .spike_empty(spike_empty), .step_run(step_run), .run_active(run_active),
    .run_finished(run_finished), .step_limit(step_limit), .step_count(step_count),
    .run_cycles(run_cycles), .cfg_inputs(cfg_inputs), .cfg_outputs(cfg_outputs),
    .cfg_threshold(cfg_threshold), .cfg_model(cfg_model), .dbg_state(dbg_state)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // host FIFO model (first-word fall-through)
  logic [511:0] rxq [0:63];
  int wr_ptr = 0;
  int rd_ptr = 0;
  assign host_empty = (wr_ptr == rd_ptr);
  assign host_word  = rxq[rd_ptr % 64];
  always @(posedge clk) if (host_pop && !host_empty) rd_ptr <= rd_ptr + 1;

  task automatic push(input logic [511:0] w);
    rxq[wr_ptr % 64] = w;
    wr_ptr++;
  endtask

  // downstream logs and pulse counters
  logic [279:0] syn_log [0:15];
  logic [53:0]  nrn_log [0:15];
  int syn_n = 0, nrn_n = 0, step_pulses = 0, axon_starts = 0;
  always @(posedge clk) begin
    if (syn_push) begin syn_log[syn_n % 16] <= syn_cmd; syn_n <= syn_n + 1; end
    if (nrn_push) begin nrn_log[nrn_n % 16] <= nrn_cmd; nrn_n <= nrn_n + 1; end
    if (step_run)   step_pulses <= step_pulses + 1;
    if (axon_start) axon_starts <= axon_starts + 1;
  end

  // engine models and observers, all at the falling edge
  int acnt = 0, pcnt = 0, p_delay = 3, glitch_at = 0;
  int qrun = 0, exits = 0, bad_exits = 0, tcount = 0, pop_busy = 0;
  logic [2:0] prev_state = 3'd0;
  always @(negedge clk) begin
    axon_done = 1'b0;
    if (axon_start) acnt = 3;
    else if (acnt > 0) begin acnt--; if (acnt == 0) axon_done = 1'b1; end
    if (step_run) begin phase2_done = 1'b0; pcnt = p_delay; end
    else if (pcnt > 0) begin pcnt--; if (pcnt == 0) phase2_done = 1'b1; end
    spike_empty = 1'b1;
    if (dbg_state == 3'd5 && glitch_at > 0 && qrun == glitch_at) begin
      spike_empty = 1'b0;
      glitch_at = 0;
    end
    if (prev_state == 3'd5 && dbg_state != 3'd5 && rst_n) begin
      exits++;
      if (qrun != 32) bad_exits++;
    end
    qrun = (dbg_state == 3'd5 && phase2_done && spike_empty) ? qrun + 1 : 0;
    prev_state = dbg_state;
    if (run_active) tcount++;
    if (host_pop && dbg_state != 3'd1) pop_busy++;
  end

  function automatic logic [511:0] mk_param(input logic [16:0] ni, input logic [16:0] no,
                                            input logic [35:0] th, input logic [1:0] md);
    logic [511:0] w;
    w = '1;
    w[511:504] = 8'd4;
    w[16:0]  = ni;
    w[33:17] = no;
    w[69:34] = th;
    w[71:70] = md;
    return w;
  endfunction

  task automatic send_param(input logic [16:0] ni, input logic [16:0] no,
                            input logic [35:0] th, input logic [1:0] md);
    push(mk_param(ni, no, th, md));
    @(negedge clk);
    check(host_empty == 1'b1, "R6 param word popped", host_empty, 1);
    check(cfg_inputs == ni, "R6 cfg_inputs", cfg_inputs, ni);
    check(cfg_outputs == no, "R6 cfg_outputs", cfg_outputs, no);
    check(cfg_threshold == signed'(th), "R6 cfg_threshold", cfg_threshold, th);
    check(cfg_model == md, "R6 cfg_model", cfg_model, md);
  endtask

  task automatic send_syn(input logic wr, input logic [22:0] addr, input logic [255:0] data, input int hold);
    logic [511:0] w;
    int n0;
    w = {512{1'b1}};
    w[511:504] = 8'd2;
    w[279] = wr; w[278:256] = addr; w[255:0] = data;
    n0 = syn_n;
    syn_full = (hold > 0);
    push(w);
    for (int i = 0; i < hold; i++) @(negedge clk);
    if (hold > 0) begin
      check(host_empty == 1'b0 && syn_n == n0, "R5 synapse held while full", syn_n - n0, 0);
      syn_full = 1'b0;
    end
    @(negedge clk);
    check(host_empty == 1'b1 && syn_n == n0 + 1, "R5 one synapse push", syn_n - n0, 1);
    check(syn_log[n0 % 16] == w[279:0], "R3 synapse packing", syn_log[n0 % 16], w[279:0]);
    check(syn_log[n0 % 16][279] == wr && syn_log[n0 % 16][278:256] == addr, "R3 flag and row",
          syn_log[n0 % 16][279:256], {wr, addr});
    check(dbg_state == 3'd1, "R5 idle after synapse", dbg_state, 1);
  endtask

  task automatic send_nrn(input logic wr, input logic [16:0] addr, input logic [35:0] data, input int hold);
    logic [511:0] w;
    int n0;
    w = {512{1'b1}};
    w[511:504] = 8'd3;
    w[53] = wr; w[52:36] = addr; w[35:0] = data;
    n0 = nrn_n;
    nrn_full = (hold > 0);
    push(w);
    for (int i = 0; i < hold; i++) @(negedge clk);
    if (hold > 0) begin
      check(host_empty == 1'b0 && nrn_n == n0, "R5 neuron held while full", nrn_n - n0, 0);
      nrn_full = 1'b0;
    end
    @(negedge clk);
    check(host_empty == 1'b1 && nrn_n == n0 + 1, "R5 one neuron push", nrn_n - n0, 1);
    check(nrn_log[n0 % 16] == {wr, addr, data}, "R4 neuron packing", nrn_log[n0 % 16], {wr, addr, data});
  endtask

  task automatic run_exec(input bit cont, input int lim, input int pd, input int gl, input bit queue_param);
    logic [511:0] w;
    int s0, a0, e0, b0, pb0, nsteps;
    s0 = step_pulses; a0 = axon_starts; e0 = exits; b0 = bad_exits; pb0 = pop_busy;
    p_delay = pd; glitch_at = gl; tcount = 0;
    w = '0;
    w[511:504] = cont ? 8'd7 : 8'd6;
    w[31:0] = cont ? 32'(lim) : 32'hA5A5_0003;
    push(w);
    @(negedge clk);
    check(run_active == 1'b1 && run_finished == 1'b0, "R8 flags at start", {run_active, run_finished}, 2'b10);
    check(step_count == 0 && run_cycles == 0, "R8 counters cleared", {step_count, run_cycles}, 0);
    check(step_limit == (cont ? 32'(lim) : 32'd0), "R8 step_limit", step_limit, cont ? lim : 0);
    check(dbg_state == (cont ? 3'd2 : 3'd4), "R2 state after execute", dbg_state, cont ? 2 : 4);
    if (queue_param) push(mk_param(17'h1ABCD, 17'h00123, 36'h8_0000_0001, 2'd2));
    while (!run_finished) @(negedge clk);
    nsteps = cont ? lim + 1 : 1;
    check(step_pulses - s0 == nsteps, "R9 one run pulse per step", step_pulses - s0, nsteps);
    check(axon_starts - a0 == (cont ? nsteps : 0), "R9 axon load per step", axon_starts - a0, cont ? nsteps : 0);
    check(step_count == (cont ? 32'(lim) : 32'd0), "R11 final step_count", step_count, cont ? lim : 0);
    check(run_active == 1'b0, "R11 running cleared", run_active, 0);
    check(run_cycles == 64'(tcount), "R12 cycle timer", run_cycles, tcount);
    check(exits - e0 == nsteps && bad_exits == b0, "R10 quiet window of 32 cycles", bad_exits - b0, 0);
    check(pop_busy == pb0, "R13 no pop while busy", pop_busy - pb0, 0);
    if (queue_param) begin
      check(host_empty == 1'b0 && cfg_model != 2'd2, "R13 queued word waited", host_empty, 0);
      @(negedge clk);
      check(cfg_inputs == 17'h1ABCD && cfg_model == 2'd2, "R13 queued word taken after run", cfg_inputs, 17'h1ABCD);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(dbg_state == 3'd0, "R1 reset state code", dbg_state, 0);
    check({run_active, run_finished} == 2'b00 && step_count == 0 && step_limit == 0 && run_cycles == 0,
          "R1 run registers zero", {run_active, run_finished, step_count, step_limit}, 0);
    check(cfg_inputs == 0 && cfg_outputs == 0 && cfg_threshold == 0 && cfg_model == 0,
          "R1 parameters zero", cfg_inputs, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dbg_state == 3'd1, "R1 idle after release", dbg_state, 1);

    // R6 parameter writes
    send_param(17'h1FFFF, 17'h00001, 36'hF_FFFF_FFFB, 2'd3);
    send_param(17'h00400, 17'h1F0F0, 36'h0_1234_5678, 2'd1);

    // R3 R5 synapse-memory commands
    send_syn(1'b1, 23'h5A5A5, {8{32'hDEAD_BEEF}}, 0);
    send_syn(1'b0, 23'h7FFFF, {8{32'h0F0F_1234}}, 3);
    send_syn(1'b1, 23'h00001, {4{64'h0123_4567_89AB_CDEF}}, 1);

    // R4 R5 neuron-state commands
    send_nrn(1'b1, 17'h1ABCD, 36'hF_0000_0001, 0);
    send_nrn(1'b0, 17'h00002, 36'h0_7777_7777, 2);
    send_nrn(1'b1, 17'h1FFFF, 36'h8_8888_8888, 1);

    // R9 standalone axon load
    begin
      int s0, a0;
      logic [511:0] w;
      s0 = step_pulses; a0 = axon_starts;
      w = '0; w[511:504] = 8'd1;
      push(w);
      @(negedge clk);
      check(dbg_state == 3'd2 && axon_start == 1'b1, "R2 axon start state", dbg_state, 2);
      @(negedge clk);
      check(dbg_state == 3'd3, "R2 axon wait state", dbg_state, 3);
      while (dbg_state != 3'd1) @(negedge clk);
      check(axon_starts - a0 == 1 && step_pulses == s0 && run_active == 1'b0,
            "R9 axon load alone", axon_starts - a0, 1);
    end

    // R8 R10 R11 R12 single step runs
    run_exec(1'b0, 0, 5, 0, 1'b0);
    run_exec(1'b0, 0, 1, 10, 1'b0);
    // continuous runs over a sweep of limits and delays
    for (int lim = 0; lim <= 4; lim++)
      run_exec(1'b1, lim, 1 + lim, (lim % 2 == 1) ? 7 + lim : 0, lim == 2);

    // R7 undefined opcode sweep
    begin
      logic [16:0] ci;
      logic [31:0] sc;
      int sn, nn, sp;
      ci = cfg_inputs; sc = step_count; sn = syn_n; nn = nrn_n; sp = step_pulses;
      for (int op = 0; op < 256; op++) begin
        if (op == 1 || op == 2 || op == 3 || op == 4 || op == 6 || op == 7) continue;
        push({8'(op), {504{1'b1}}});
        @(negedge clk);
        check(host_empty && dbg_state == 3'd1 && syn_n == sn && nrn_n == nn && step_pulses == sp &&
              cfg_inputs == ci && step_count == sc && run_finished == 1'b1,
              "R7 undefined opcode dropped", op, 0);
      end
    end

    // R1 reset during a run
    begin
      logic [511:0] w;
      w = '0; w[511:504] = 8'd7; w[31:0] = 32'd3;
      p_delay = 2;
      push(w);
      while (dbg_state != 3'd5) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(dbg_state == 3'd0 && run_active == 1'b0 && run_finished == 1'b0, "R1 async reset mid-run",
            {dbg_state, run_active, run_finished}, 0);
      check(step_limit == 0 && run_cycles == 0 && cfg_inputs == 0 && cfg_threshold == 0,
            "R1 registers cleared mid-run", step_limit, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(dbg_state == 3'd1, "R1 idle after second release", dbg_state, 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule